// File: doc/BRIEF.md
# Command Queue Drain Engine

This block empties a ring of fixed-size commands that software places in memory. Software supplies the ring's base address, its entry count and a write offset that marks the end of valid work. The block keeps its own read offset. While the two offsets differ, it fetches the first 64-bit word of the command at the read offset and classifies the opcode in its low byte. Commands with a recognised opcode go to an external handler. All other opcodes are dropped without handler involvement.

The handler returns one of two results. "Continue" moves the read offset on by one entry, wrapping to zero at the entry count. The handler also returns "continue" for commands whose parameters are wrong, so those commands are simply passed over. "Stall" freezes the ring. A faulted memory read freezes it the same way. In both cases a sticky stalled flag is raised and the read offset stays on the offending entry. Software repairs the cause and pulses the clear input, and draining resumes from that same entry.

Both data-carrying interfaces are valid/ready. The memory request and the handler dispatch hold valid, with a stable payload, until ready is seen high at a clock edge. The memory response and the handler result are consumed only in the cycle where the block drives its ready high. Only one transaction is in flight across the two interfaces at any time. Configuration, offsets, the clear input and the stalled flag are plain level signals.

Top module: `cmdq_drain`

## Requirements
- R1: A synchronous active-high reset sets the read offset to 0, clears the stalled flag and deasserts every valid and ready output of the block.
- R2: The block issues a fetch only while the read offset differs from the write offset and the stalled flag is clear. Once the read offset equals the write offset it stays idle.
- R3: Each fetch requests address base + read_offset × 32. At most one of memory request, memory response, handler dispatch and handler result is outstanding at a time.
- R4: The opcode is bits [7:0] of the fetched word. Opcodes 0x01 to 0x0F inclusive are dispatched to the handler with the full fetched word and the current read offset.
- R5: Any other opcode (0x00, or 0x10 to 0xFF) is skipped. It causes no handler dispatch, and the read offset advances.
- R6: A "continue" result (done_stall = 0) advances the read offset by one, wrapping from count−1 to 0.
- R7: A memory response with the error bit set raises the stalled flag. The read offset is left unchanged and nothing is dispatched for that entry.
- R8: A "stall" result (done_stall = 1) raises the stalled flag and leaves the read offset on the command that produced it.
- R9: While stalled, no memory request is issued. A pulse on stall_clear drops the flag, and processing restarts at the unchanged read offset, refetching the same entry.
- R10: The memory request and the handler dispatch keep valid high and their payload stable until accepted by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | Byte address of ring entry 0 |
| cfg_count | input | IDX_W+1 | Number of ring entries |
| wr_offset | input | IDX_W | Software write offset |
| stall_clear | input | 1 | Pulse to drop the stalled flag |
| rd_offset | output | IDX_W | Current read offset |
| stalled | output | 1 | Sticky stalled flag |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | ADDR_W | Fetch byte address |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_ready | output | 1 | Block takes the response |
| mem_rsp_data | input | WORD_W | First command word |
| mem_rsp_err | input | 1 | Fetch faulted |
| hnd_valid | output | 1 | Dispatch valid |
| hnd_ready | input | 1 | Handler accepts dispatch |
| hnd_opcode | output | 8 | Opcode of dispatched command |
| hnd_word | output | WORD_W | Dispatched command word |
| hnd_offset | output | IDX_W | Ring index of dispatched command |
| done_valid | input | 1 | Handler result valid |
| done_ready | output | 1 | Block takes the result |
| done_stall | input | 1 | 1 = stall, 0 = continue |

## Verification
The hardest situation to reach from the ports is a freeze followed by a resume on the very same entry. Handler stalls and fetch faults must each be reached, including at positions where the ring wraps around or sits next to skipped opcodes. The bench gets there by planting faulting entries and stall-marked commands in its memory model. After each freeze it patches the offending entry and pulses the clear input, so the same offset is refetched and draining carries on. Random rounds with random latencies on both interfaces then mix all cases across ring sizes of 3, 16 and 64 entries.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int ENTRY_SHIFT = 5;       // 32-byte ring entries
  localparam int OPC_W       = 8;
  localparam logic [OPC_W-1:0] OPC_FIRST = 8'h01;
  localparam logic [OPC_W-1:0] OPC_LAST  = 8'h0F;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_DISP,
    S_WAIT
  } seq_state_t;
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic             known
);
  always_comb begin
    known = (opcode >= OPC_FIRST) && (opcode <= OPC_LAST);
  end
endmodule

// File: rtl/cmdq_addr.sv
module cmdq_addr
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    addr = base + (ADDR_W'(index) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/cmdq_ptr.sv
module cmdq_ptr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W:0]   count,
  input  logic             advance,
  input  logic             set_stall,
  input  logic             clear_stall,
  output logic [IDX_W-1:0] rd_q,
  output logic             stall_q
);
  logic [IDX_W:0]   inc;
  logic [IDX_W-1:0] rd_d;
  logic             stall_d;

  always_comb begin
    inc  = {1'b0, rd_q} + 1'b1;
    rd_d = rd_q;
    if (advance) begin
      rd_d = (inc >= count) ? '0 : inc[IDX_W-1:0];
    end
    stall_d = stall_q;
    if (set_stall) begin
      stall_d = 1'b1;
    end else if (clear_stall) begin
      stall_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      stall_q <= stall_d;
    end
  end

  // R6: the offset only moves as the result of an advance request
  a_r6_move_on_advance: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_q) |-> $past(advance));
  // R9: the flag is sticky until cleared
  a_r9_sticky_stall: assert property (@(posedge clk) disable iff (rst)
    stall_q && !clear_stall |=> stall_q);
  // R8: a raised flag never coincides with a move of the offset
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_q) |-> $stable(rd_q));
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pending,
  input  logic              stalled,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              rsp_known,
  input  logic              hnd_ready,
  input  logic              done_valid,
  input  logic              done_stall,
  output logic              mem_req_valid,
  output logic              mem_rsp_ready,
  output logic              hnd_valid,
  output logic              done_ready,
  output logic              advance,
  output logic              set_stall,
  output logic [WORD_W-1:0] cmd_word
);
  seq_state_t state_q, state_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    state_d   = state_q;
    word_d    = word_q;
    advance   = 1'b0;
    set_stall = 1'b0;
    unique case (state_q)
      S_IDLE: if (pending && !stalled) state_d = S_REQ;
      S_REQ:  if (mem_req_ready) state_d = S_RSP;
      S_RSP: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            set_stall = 1'b1;
            state_d   = S_IDLE;
          end else if (rsp_known) begin
            word_d  = mem_rsp_data;
            state_d = S_DISP;
          end else begin
            advance = 1'b1;
            state_d = S_IDLE;
          end
        end
      end
      S_DISP: if (hnd_ready) state_d = S_WAIT;
      S_WAIT: begin
        if (done_valid) begin
          if (done_stall) set_stall = 1'b1;
          else            advance   = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
    end
  end

  assign mem_req_valid = (state_q == S_REQ);
  assign mem_rsp_ready = (state_q == S_RSP);
  assign hnd_valid     = (state_q == S_DISP);
  assign done_ready    = (state_q == S_WAIT);
  assign cmd_word      = word_q;

  // R3: a single transaction phase at a time
  a_r3_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_req_valid, mem_rsp_ready, hnd_valid, done_ready}));
  // R2: a fetch starts only when work was pending
  a_r2_fetch_needs_work: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> $past(pending) && !$past(stalled));
  // R10: dispatch payload held until accepted
  a_r10_hnd_hold: assert property (@(posedge clk) disable iff (rst)
    hnd_valid && !hnd_ready |=> hnd_valid && $stable(cmd_word));
endmodule

// File: rtl/cmdq_drain.sv
module cmdq_drain
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_count,
  input  logic [IDX_W-1:0]  wr_offset,
  input  logic              stall_clear,
  output logic [IDX_W-1:0]  rd_offset,
  output logic              stalled,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              hnd_valid,
  input  logic              hnd_ready,
  output logic [7:0]        hnd_opcode,
  output logic [WORD_W-1:0] hnd_word,
  output logic [IDX_W-1:0]  hnd_offset,
  input  logic              done_valid,
  output logic              done_ready,
  input  logic              done_stall
);
  logic              advance;
  logic              set_stall;
  logic              rsp_known;
  logic [WORD_W-1:0] cmd_word;
  logic              pending;

  assign pending = (rd_offset != wr_offset);

  cmdq_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst(rst), .count(cfg_count), .advance(advance),
    .set_stall(set_stall), .clear_stall(stall_clear),
    .rd_q(rd_offset), .stall_q(stalled)
  );

  cmdq_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base(cfg_base), .index(rd_offset), .addr(mem_req_addr)
  );

  cmdq_decode u_dec (
    .opcode(mem_rsp_data[OPC_W-1:0]), .known(rsp_known)
  );

  cmdq_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst(rst), .pending(pending), .stalled(stalled),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .rsp_known(rsp_known), .hnd_ready(hnd_ready),
    .done_valid(done_valid), .done_stall(done_stall),
    .mem_req_valid(mem_req_valid), .mem_rsp_ready(mem_rsp_ready),
    .hnd_valid(hnd_valid), .done_ready(done_ready),
    .advance(advance), .set_stall(set_stall), .cmd_word(cmd_word)
  );

  assign hnd_word   = cmd_word;
  assign hnd_opcode = cmd_word[OPC_W-1:0];
  assign hnd_offset = rd_offset;

  // R4: only recognised opcodes reach the handler
  a_r4_known_dispatch: assert property (@(posedge clk) disable iff (rst)
    hnd_valid |-> (hnd_opcode >= OPC_FIRST) && (hnd_opcode <= OPC_LAST));
  // R7: a faulted fetch freezes the ring on the same entry
  a_r7_fault_stalls: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && mem_rsp_ready && mem_rsp_err |=> stalled && $stable(rd_offset));
  // R9: no fetch while frozen
  a_r9_quiet_when_stalled: assert property (@(posedge clk) disable iff (rst)
    stalled |-> !mem_req_valid);
  // R10: request address held until accepted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: tb/cmdq_drain_test.sv
module cmdq_drain_test;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 6;
  localparam int WORD_W = 64;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W:0]    cfg_count = 7'd8;
  logic [IDX_W-1:0]  wr_offset = '0;
  logic stall_clear = 1'b0;
  logic [IDX_W-1:0] rd_offset;
  logic stalled;
  logic mem_req_valid, mem_rsp_ready, hnd_valid, done_ready;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [WORD_W-1:0] mem_rsp_data = '0;
  logic mem_rsp_err = 1'b0;
  logic hnd_ready = 1'b0;
  logic [7:0] hnd_opcode;
  logic [WORD_W-1:0] hnd_word;
  logic [IDX_W-1:0] hnd_offset;
  logic done_valid = 1'b0;
  logic done_stall = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cmdq_drain #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WORD_W(WORD_W)) uut (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_count(cfg_count),
    .wr_offset(wr_offset), .stall_clear(stall_clear), .rd_offset(rd_offset),
    .stalled(stalled), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err), .hnd_valid(hnd_valid), .hnd_ready(hnd_ready),
    .hnd_opcode(hnd_opcode), .hnd_word(hnd_word), .hnd_offset(hnd_offset),
    .done_valid(done_valid), .done_ready(done_ready), .done_stall(done_stall)
  );

  int compared = 0;
  int mismatched = 0;
  logic [WORD_W-1:0] mem_data [DEPTH];
  bit                mem_err  [DEPTH];
  logic [WORD_W-1:0] exp_word_q [$];
  int                exp_off_q  [$];
  int  exp_rd = 0;
  bit  exp_stall = 1'b0;
  bit  finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_known(logic [7:0] op);
    return (op >= 8'h01) && (op <= 8'h0F);
  endfunction

  // Walk the ring from exp_rd to target, as the requirements describe
  task automatic model(int target);
    int r = exp_rd;
    while (r != target) begin
      if (mem_err[r]) begin exp_stall = 1'b1; break; end
      if (is_known(mem_data[r][7:0])) begin
        exp_word_q.push_back(mem_data[r]);
        exp_off_q.push_back(r);
        if (mem_data[r][63]) begin exp_stall = 1'b1; break; end
      end
      r = (r + 1) % int'(cfg_count);
    end
    exp_rd = r;
  endtask

  // Memory responder (R3, R10)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid) begin
        int idx;
        repeat ($urandom % 3) @(negedge clk);
        chk(mem_req_addr == cfg_base + (ADDR_W'(rd_offset) << 5), "R3",
            "fetch address", longint'(mem_req_addr),
            longint'(cfg_base + (ADDR_W'(rd_offset) << 5)));
        idx = int'(rd_offset);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_data  = mem_data[idx];
        mem_rsp_err   = mem_err[idx];
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
      end
    end
  end

  // Handler responder (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && hnd_valid) begin
        logic [WORD_W-1:0] w;
        repeat ($urandom % 3) @(negedge clk);
        if (exp_word_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected dispatch at offset", longint'(hnd_offset), -1);
        end else begin
          w = exp_word_q.pop_front();
          chk(hnd_word == w, "R4", "dispatched word", longint'(hnd_word), longint'(w));
          chk(hnd_opcode == w[7:0], "R4", "dispatched opcode", longint'(hnd_opcode),
              longint'(w[7:0]));
          chk(int'(hnd_offset) == exp_off_q[0], "R4", "dispatched offset",
              longint'(hnd_offset), longint'(exp_off_q[0]));
          void'(exp_off_q.pop_front());
        end
        w = hnd_word;
        hnd_ready = 1'b1;
        @(negedge clk);
        hnd_ready = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
        done_stall = w[63];
        done_valid = 1'b1;
        @(negedge clk);
        done_valid = 1'b0;
        done_stall = 1'b0;
      end
    end
  end

  task automatic wait_quiet();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(stalled || rd_offset == wr_offset) && n < 20000);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset(logic [IDX_W:0] cnt, logic [ADDR_W-1:0] base);
    @(negedge clk);
    rst = 1'b1;
    cfg_count = cnt;
    cfg_base = base;
    wr_offset = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_rd = 0;
    exp_stall = 1'b0;
    @(negedge clk);
    chk(rd_offset == 0, "R1", "reset read offset", longint'(rd_offset), 0);
    chk(!stalled, "R1", "reset stalled flag", longint'(stalled), 0);
    chk(!mem_req_valid && !hnd_valid && !mem_rsp_ready && !done_ready, "R1",
        "reset handshake outputs", longint'({mem_req_valid, hnd_valid}), 0);
  endtask

  // Drain to target; on every freeze, patch the entry, clear and resume
  task automatic run(int target);
    int guard = 0;
    model(target);
    wr_offset = IDX_W'(target);
    wait_quiet();
    while (exp_stall && guard < 8) begin
      int quiet = 1;
      chk(stalled == 1'b1, "R8", "stalled flag raised", longint'(stalled), 1);
      chk(int'(rd_offset) == exp_rd, "R7", "read offset held on failing entry",
          longint'(rd_offset), longint'(exp_rd));
      repeat (16) begin
        @(negedge clk);
        if (mem_req_valid) quiet = 0;
      end
      chk(quiet == 1, "R9", "no fetch while stalled", longint'(quiet), 1);
      mem_err[exp_rd] = 1'b0;
      mem_data[exp_rd][63] = 1'b0;
      stall_clear = 1'b1;
      @(negedge clk);
      stall_clear = 1'b0;
      exp_stall = 1'b0;
      model(target);
      wait_quiet();
      guard++;
    end
    chk(int'(rd_offset) == exp_rd, "R6", "final read offset", longint'(rd_offset),
        longint'(exp_rd));
    chk(stalled == exp_stall, "R2", "final stalled flag", longint'(stalled),
        longint'(exp_stall));
    chk(exp_word_q.size() == 0, "R4", "all expected dispatches seen",
        longint'(exp_word_q.size()), 0);
    exp_word_q.delete();
    exp_off_q.delete();
  endtask

  task automatic fill_random(int cnt);
    for (int i = 0; i < cnt; i++) begin
      mem_data[i] = {$urandom, $urandom};
      mem_data[i][7:0] = 8'($urandom % 20);
      mem_data[i][63] = ($urandom % 8) == 0;
      mem_err[i] = ($urandom % 10) == 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      mem_data[i] = '0;
      mem_err[i] = 1'b0;
    end
    do_reset(7'd8, 48'h1000);
    // Directed: known, unknown (R5), handler stall (R8), fetch fault (R7), wrap (R6)
    mem_data[0] = 64'h0000_1111_0000_0001;
    mem_data[1] = 64'h0000_2222_0000_000F;
    mem_data[2] = 64'h0000_3333_0000_0000;
    mem_data[3] = 64'h0000_4444_0000_0010;
    mem_data[4] = 64'h0000_5555_0000_0005;
    mem_data[5] = 64'h8000_6666_0000_0008;
    mem_data[6] = 64'h0000_7777_0000_0003;
    mem_err[6]  = 1'b1;
    mem_data[7] = 64'h0000_8888_0000_00FF;
    run(5);
    run(2);
    // Idle when offsets equal (R2)
    run(2);
    // Random rounds over several ring sizes
    foreach (mem_data[k]) mem_data[k] = '0;
    for (int ph = 0; ph < 3; ph++) begin
      int cnt = (ph == 0) ? 3 : (ph == 1) ? 16 : 64;
      do_reset(7'(cnt), 48'(($urandom % 4096) << 11));
      for (int rnd = 0; rnd < 12; rnd++) begin
        fill_random(cnt);
        run(int'($urandom % cnt));
      end
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule